// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block turns a low-supply indication into an active-low reset for a host processor. Two detect inputs arrive from an analog comparator, one per trip level, and a bit in a small control register picks which one counts as a supply fault. A fault pulls reset low in the same cycle. Reset stays low for as long as the fault lasts. When the supply recovers, reset is held for a fixed number of reference ticks before it is let go. At 1 ms per tick, the default count of 100 gives about 100 ms.

The block raises a bus-lockout flag whenever reset is pulled low, so no new serial transaction is accepted. A memory operation that was already running when the fault came is allowed to finish. The abort request to the memory controller is withheld until the controller's busy input drops. At power-up the block starts with reset pulled low and a cleared hold count, so the first release comes only after a full hold period.

Top module: `pfr_supervisor`

## Requirements
- R1: Reset is pulled low (`rst_pull_low`=1) in the same cycle that the selected detect input is high.
- R2: `rst_pull_low` stays 1 on every cycle in which the selected detect input stays high.
- R3: Once the selected detect input is low, `rst_pull_low` returns to 0 in the cycle after the rising clock edge that samples the HOLD_TICKS-th `tick` pulse seen with no fault. `rst_pull_low`=0 means released (weak high), not driven.
- R4: If a fault occurs during the hold period, the tick count restarts from zero.
- R5: After `rst_n` reset, `rst_pull_low` is 1 and a full HOLD_TICKS ticks are needed for the first release.
- R6: `bus_lock` is 1 exactly when `rst_pull_low` is 1.
- R7: `mem_abort` is 1 only when reset is pulled low and `mem_busy` is 0. A busy memory operation is therefore never aborted until `mem_busy` drops.
- R8: Trip select (`trip_sel`, reset value 0) takes `cfg_wdata[0]` on a clock edge with `cfg_wr`=1. A value of 0 selects `below_lo` and a value of 1 selects `below_hi`.
- R9: Bits of `cfg_wdata` other than bit 0 have no effect on `trip_sel` or on reset behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick | input | 1 | Reference tick pulse for the hold timer |
| below_lo | input | 1 | Supply under lower trip level |
| below_hi | input | 1 | Supply under upper trip level |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data, bit 0 = trip select |
| mem_busy | input | 1 | Memory operation in progress |
| trip_sel | output | 1 | Current trip select value |
| rst_pull_low | output | 1 | 1 = pull processor reset low |
| bus_lock | output | 1 | 1 = refuse new bus transactions |
| mem_abort | output | 1 | Abort request to memory controller |

## Verification
The hardest case to reach is a supply dip that lands near the end of the hold period, when the count is one tick short of release. The stimulus recovers the supply, sends exactly HOLD_TICKS-1 ticks, and then raises the detect input for one cycle together with a tick. This shows that the tick is discarded and that a full count follows. A second hard case is a fault that arrives while the memory is busy. Here `mem_busy` is kept high across the fault and is dropped several cycles later, and the abort request is watched for the cycle in which it first appears.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic {
    PFR_ASSERT = 1'b0,
    PFR_RUN    = 1'b1
  } pfr_state_e;

  function automatic logic hold_last(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

  function automatic logic pick_fault(input logic sel, input logic lo, input logic hi);
    return sel ? hi : lo;
  endfunction
endpackage

// File: rtl/pfr_trip_reg.sv
module pfr_trip_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic             sel
);
  logic unused_upper;
  assign unused_upper = ^wdata[CFG_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel <= 1'b0;
    else if (wr) sel <= wdata[0];
  end
endmodule

// File: rtl/pfr_hold_ctr.sv
module pfr_hold_ctr #(
  parameter int HOLD_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic tick,
  output logic expire
);
  import pfr_pkg::*;
  localparam int CW = $clog2(HOLD_TICKS + 1);
  logic [CW-1:0] cnt;

  assign expire = enable && tick && hold_last(int'(cnt), HOLD_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear || !enable)  cnt <= '0;
    else if (expire)            cnt <= '0;
    else if (tick)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pfr_seq.sv
module pfr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic expire,
  output logic holding,
  output logic pull_low
);
  import pfr_pkg::*;
  pfr_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= PFR_ASSERT;
    else if (fault)  state <= PFR_ASSERT;
    else if (expire) state <= PFR_RUN;
  end

  assign holding  = (state == PFR_ASSERT) && !fault;
  assign pull_low = (state == PFR_ASSERT) || fault;
endmodule

// File: rtl/pfr_supervisor.sv
module pfr_supervisor #(
  parameter int HOLD_TICKS = 100,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             below_lo,
  input  logic             below_hi,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mem_busy,
  output logic             trip_sel,
  output logic             rst_pull_low,
  output logic             bus_lock,
  output logic             mem_abort
);
  import pfr_pkg::*;

  logic fault;
  logic holding;
  logic hold_expire;

  pfr_trip_reg #(.CFG_W(CFG_W)) u_trip (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .sel(trip_sel)
  );

  assign fault = pick_fault(trip_sel, below_lo, below_hi);

  pfr_hold_ctr #(.HOLD_TICKS(HOLD_TICKS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(fault), .enable(holding),
    .tick(tick), .expire(hold_expire)
  );

  pfr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fault(fault), .expire(hold_expire),
    .holding(holding), .pull_low(rst_pull_low)
  );

  assign bus_lock  = rst_pull_low;
  assign mem_abort = rst_pull_low && !mem_busy;
endmodule

// File: rtl/pfr_supervisor_chk.sv
module pfr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       below_lo,
  input logic       below_hi,
  input logic       cfg_wr,
  input logic       cfg_bit0,
  input logic       mem_busy,
  input logic       trip_sel,
  input logic       rst_pull_low,
  input logic       bus_lock,
  input logic       mem_abort,
  input logic       hold_expire
);
  a_r1_fault_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_sel ? below_hi : below_lo)) |-> rst_pull_low);

  a_r3_release_needs_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull_low) |-> $past(hold_expire));

  a_r6_lock_tracks_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock == rst_pull_low);

  a_r7_no_abort_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !mem_abort);

  a_r7_abort_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pull_low && !mem_busy) |-> mem_abort);

  a_r8_trip_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (trip_sel == $past(cfg_bit0)));
endmodule

bind pfr_supervisor pfr_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .below_lo(below_lo), .below_hi(below_hi),
  .cfg_wr(cfg_wr), .cfg_bit0(cfg_wdata[0]), .mem_busy(mem_busy),
  .trip_sel(trip_sel), .rst_pull_low(rst_pull_low), .bus_lock(bus_lock),
  .mem_abort(mem_abort), .hold_expire(hold_expire)
);

// File: tb/pfr_supervisor_test.sv
module pfr_supervisor_test;
  localparam int HOLD = 6;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, below_lo = 1'b0, below_hi = 1'b0, cfg_wr = 1'b0, mem_busy = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic trip_sel, rst_pull_low, bus_lock, mem_abort;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  bit m_up = 0;
  bit m_trip = 0;

  pfr_supervisor #(.HOLD_TICKS(HOLD), .CFG_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .below_lo(below_lo), .below_hi(below_hi),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .mem_busy(mem_busy),
    .trip_sel(trip_sel), .rst_pull_low(rst_pull_low), .bus_lock(bus_lock),
    .mem_abort(mem_abort)
  );

  always #10 clk = ~clk;

  // behavioural reference: ticks seen since last fault, release flag
  always @(posedge clk) begin
    bit f;
    if (!rst_n) begin
      m_cnt = 0; m_up = 0; m_trip = 0;
    end else begin
      f = m_trip ? below_hi : below_lo;
      if (f) begin
        m_cnt = 0; m_up = 0;
      end else if (!m_up && tick) begin
        m_cnt++;
        if (m_cnt >= HOLD) begin m_up = 1; m_cnt = 0; end
      end
      if (cfg_wr) m_trip = cfg_wdata[0];
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit f, low;
    f = m_trip ? below_hi : below_lo;
    low = !m_up || f;
    chk("R8 trip_sel", trip_sel, m_trip);
    chk("R1/R2/R3/R4 rst_pull_low", rst_pull_low, low);
    chk("R6 bus_lock", bus_lock, low);
    chk("R7 mem_abort", mem_abort, low && !mem_busy);
  endtask

  task automatic step(input logic t, input logic lo, input logic hi,
                      input logic busy, input logic wr, input logic [CW-1:0] wd);
    @(negedge clk);
    tick = t; below_lo = lo; below_hi = hi; mem_busy = busy; cfg_wr = wr; cfg_wdata = wd;
    #1 compare();
  endtask

  task automatic idle(input int n, input logic t);
    for (int i = 0; i < n; i++) step(t, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        chk("R5 reset pulls low", rst_pull_low, 1'b1);
        chk("R8 trip_sel reset value", trip_sel, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // R5: first release only after full hold
        idle(HOLD - 1, 1'b1);
        chk("R5 still held before last tick", rst_pull_low, 1'b1);
        idle(3, 1'b1);
        chk("R5 released after full hold", rst_pull_low, 1'b0);
        // R1/R2: lower level fault with trip_sel=0
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R1 immediate pull low", rst_pull_low, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        chk("R2 held during fault", rst_pull_low, 1'b1);
        // R3 with sparse ticks
        for (int i = 0; i < 4 * HOLD; i++) step(i % 3 == 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R3 released with sparse ticks", rst_pull_low, 1'b0);
        // R4: dip one tick before release
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        idle(HOLD - 1, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        idle(HOLD - 1, 1'b1);
        chk("R4 count restarted", rst_pull_low, 1'b1);
        idle(2, 1'b1);
        chk("R4 release after full recount", rst_pull_low, 1'b0);
        // R8: upper level selected; below_lo alone no longer a fault
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R8 lower detect ignored when upper selected", rst_pull_low, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        chk("R8 upper detect faults", rst_pull_low, 1'b1);
        idle(HOLD + 2, 1'b1);
        // R9: bit1 and upper bits ignored
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFE);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 upper bits ignored, trip_sel", trip_sel, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        chk("R9 upper detect no fault", rst_pull_low, 1'b0);
        // R7: fault during busy memory op
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        chk("R7 no abort while busy", mem_abort, 1'b0);
        chk("R6 lock while busy", bus_lock, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        chk("R7 abort once idle", mem_abort, 1'b1);
        idle(HOLD + 2, 1'b1);
        chk("R7 no abort after release", mem_abort, 1'b0);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule